// File: doc/BRIEF.md
# Candidate-Channel Lock Synchronizer

On the receive side of a serial link, the deserializer hands this block a group of bit pairs once per reference period. Each candidate bit position in the group contributes one 2-bit pair per period. The command channel sits at one of these positions, but which one is not known after power-up or after the link drops. The block watches every active candidate for a fixed four-period synchronization sequence and keeps a separate hit count per candidate. It declares lock on the first candidate whose count reaches a programmable lock threshold.

Once locked, the block expects the sequence on the chosen candidate every fourth period and raises a phase strobe in that period.

- A hit in an expected period raises the chosen candidate's count, saturating at the lock threshold.
- A miss in an expected period lowers the count.
- When the count falls to the programmable unlock threshold, the block returns to searching and clears every count.

A speed select sets how many candidates take part: 4, 8 or 16.

Top module: `lane_lock_sync`

## Requirements
- R1: While reset (`rst_n` low) is applied and in the first cycle after it, `locked`, `chan_idx` and `phase_strobe` are all 0.
- R2: Candidate i is taken from `rx_pairs[2i+1:2i]`. A sync hit on candidate i occurs in a cycle when its pairs over four consecutive cycles were 2'b11, 2'b01, 2'b10, 2'b00, with 2'b00 in the current cycle. Any other order or an incomplete sequence is not a hit.
- R3: While searching, each hit on an active candidate raises its count by one, saturating at 2^CNT_W-1. When a hit brings a count to at least `lock_thr`, `locked` is 1 from the next cycle.
- R4: `speed_sel` 0 makes candidates 0..3 active, 1 makes 0..7 active, and 2 or 3 makes 0..15 active. Hits on inactive candidates are ignored.
- R5: If several candidates reach `lock_thr` in the same cycle, the lowest index is selected. `chan_idx` holds the selected index while locked and keeps it after lock is lost.
- R6: While locked, `phase_strobe` is 1 in every fourth cycle. The first strobe falls four cycles after the cycle that completed the locking sequence. The strobe is never 1 while searching.
- R7: In a strobe cycle, a hit on the selected candidate raises its count, but never past `lock_thr`. A miss lowers the count by one (floor 0). If the lowered count is at or below `unlock_thr`, `locked` is 0 from the next cycle.
- R8: Losing lock clears every candidate count, so a new lock needs `lock_thr` fresh hits.
- R9: While locked, hits on other candidates, and hits on the selected candidate outside strobe cycles, change neither the lock nor `chan_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pairs | input | 2*MAX_CH | Deserialized bit pairs, two bits per candidate |
| speed_sel | input | 2 | Number of active candidates (4, 8, 16) |
| lock_thr | input | CNT_W | Count needed to declare lock |
| unlock_thr | input | CNT_W | Count at or below which lock is lost |
| locked | output | 1 | 1 while locked to a candidate |
| chan_idx | output | $clog2(MAX_CH) | Selected candidate index |
| phase_strobe | output | 1 | Expected sync period while locked |

## Verification
Two events can fall in the same cycle.

- **Several candidates reaching the lock threshold together.** The bench provokes this by driving the sequence on two candidates at once. It judges the result by the index reported after the lock.
- **A strobe-cycle miss coinciding with a fresh hit elsewhere.** The bench drives a sequence on a non-selected candidate while the selected one goes quiet. The expected outcome is that the lock drops on the miss and the other candidate gains nothing.

A behavioural model fed with pseudo-random pairs, speed changes and threshold changes provokes further collisions, and its outputs are compared on every clock.

// File: rtl/lls_pkg.sv
package lls_pkg;
  typedef enum logic {ST_SEARCH = 1'b0, ST_LOCKED = 1'b1} lls_state_e;

  localparam int unsigned SYNC_LEN = 4;

  // Pair expected in position k of the sync sequence (0 = oldest).
  function automatic logic [1:0] sync_pair(input int unsigned k);
    case (k)
      0:       return 2'b11;
      1:       return 2'b01;
      2:       return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // Number of candidate positions taking part at a given speed.
  function automatic int unsigned active_count(input logic [1:0] spd);
    case (spd)
      2'd0:    return 4;
      2'd1:    return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/lls_detect.sv
module lls_detect #(
  parameter int unsigned MAX_CH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*MAX_CH-1:0]   rx_pairs,
  output logic [MAX_CH-1:0]     hit
);
  import lls_pkg::*;

  for (genvar g = 0; g < MAX_CH; g++) begin : g_cand
    logic [1:0] cur;
    logic [1:0] h0, h1, h2;   // h0 newest, h2 oldest
    assign cur = rx_pairs[2*g +: 2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        h0 <= '0;
        h1 <= '0;
        h2 <= '0;
      end else begin
        h2 <= h1;
        h1 <= h0;
        h0 <= cur;
      end
    end

    assign hit[g] = (h2 == sync_pair(0)) && (h1 == sync_pair(1)) &&
                    (h0 == sync_pair(2)) && (cur == sync_pair(SYNC_LEN-1));
  end
endmodule

// File: rtl/lls_counters.sv
module lls_counters #(
  parameter int unsigned MAX_CH = 16,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAX_CH-1:0] hit,
  input  logic [MAX_CH-1:0] act_mask,
  input  logic              searching,
  input  logic              slot,
  input  logic [CH_W-1:0]   sel_idx,
  input  logic              clear,
  input  logic [CNT_W-1:0]  lock_thr,
  input  logic [CNT_W-1:0]  unlock_thr,
  output logic [MAX_CH-1:0] ripe,
  output logic              drop
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_arr [MAX_CH];

  for (genvar g = 0; g < MAX_CH; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             count_here;
    logic             is_sel;

    assign cnt_arr[g]  = cnt_q;
    assign is_sel      = (sel_idx == CH_W'(g));
    assign count_here  = searching && hit[g] && act_mask[g];
    assign ripe[g]     = count_here && (step_up(cnt_q) >= lock_thr);

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        cnt_q <= '0;
      end else if (count_here) begin
        cnt_q <= step_up(cnt_q);
      end else if (slot && is_sel) begin
        if (hit[g]) cnt_q <= (cnt_q < lock_thr) ? step_up(cnt_q) : cnt_q;
        else        cnt_q <= step_down(cnt_q);
      end
    end
  end

  logic [CNT_W-1:0] sel_cnt;
  logic             sel_hit;
  assign sel_cnt = cnt_arr[sel_idx];
  assign sel_hit = hit[sel_idx];
  assign drop    = slot && !sel_hit && (step_down(sel_cnt) <= unlock_thr);
endmodule

// File: rtl/lls_ctrl.sv
module lls_ctrl #(
  parameter int unsigned MAX_CH = 16,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAX_CH-1:0] ripe,
  input  logic              drop,
  output logic              searching,
  output logic              slot,
  output logic              lock_event,
  output logic [CH_W-1:0]   sel_idx
);
  import lls_pkg::*;

  lls_state_e      state_q;
  logic [1:0]      phase_q;
  logic [CH_W-1:0] pick;

  // Lowest ripe index wins.
  always_comb begin
    pick = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (ripe[i]) pick = CH_W'(i);
    end
  end

  assign searching  = (state_q == ST_SEARCH);
  assign lock_event = searching && (|ripe);
  assign slot       = (state_q == ST_LOCKED) && (phase_q == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      sel_idx <= '0;
      phase_q <= '0;
    end else if (lock_event) begin
      state_q <= ST_LOCKED;
      sel_idx <= pick;
      phase_q <= 2'd1;
    end else begin
      phase_q <= phase_q + 2'd1;
      if (state_q == ST_LOCKED && drop) state_q <= ST_SEARCH;
    end
  end
endmodule

// File: rtl/lane_lock_sync.sv
module lane_lock_sync #(
  parameter int unsigned MAX_CH = 16,
  parameter int unsigned CNT_W  = 6,
  localparam int unsigned CH_W  = $clog2(MAX_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*MAX_CH-1:0] rx_pairs,
  input  logic [1:0]          speed_sel,
  input  logic [CNT_W-1:0]    lock_thr,
  input  logic [CNT_W-1:0]    unlock_thr,
  output logic                locked,
  output logic [CH_W-1:0]     chan_idx,
  output logic                phase_strobe
);
  import lls_pkg::*;

  logic [MAX_CH-1:0] hit;
  logic [MAX_CH-1:0] act_mask;
  logic [MAX_CH-1:0] ripe;
  logic              drop_event;
  logic              lock_event;
  logic              searching;
  logic              slot;
  logic [CH_W-1:0]   sel;

  for (genvar g = 0; g < MAX_CH; g++) begin : g_mask
    assign act_mask[g] = (int'(g) < int'(active_count(speed_sel)));
  end

  lls_detect #(.MAX_CH(MAX_CH)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_pairs (rx_pairs),
    .hit      (hit)
  );

  lls_counters #(.MAX_CH(MAX_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_counters (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .act_mask   (act_mask),
    .searching  (searching),
    .slot       (slot),
    .sel_idx    (sel),
    .clear      (drop_event),
    .lock_thr   (lock_thr),
    .unlock_thr (unlock_thr),
    .ripe       (ripe),
    .drop       (drop_event)
  );

  lls_ctrl #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ripe       (ripe),
    .drop       (drop_event),
    .searching  (searching),
    .slot       (slot),
    .lock_event (lock_event),
    .sel_idx    (sel)
  );

  assign locked       = !searching;
  assign chan_idx     = sel;
  assign phase_strobe = slot;
endmodule

// File: rtl/lls_checker.sv
module lls_checker #(
  parameter int unsigned CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      speed_sel,
  input logic            locked,
  input logic [CH_W-1:0] chan_idx,
  input logic            phase_strobe,
  input logic            lock_event,
  input logic            drop_event
);
  import lls_pkg::*;

  assert_lock_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_event |=> locked);

  assert_drop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_event |=> !locked);

  assert_drop_only_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_event |-> locked);

  assert_strobe_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_strobe |-> locked);

  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_strobe |=> !phase_strobe);

  assert_first_cycle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !phase_strobe);

  assert_chan_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(chan_idx));

  assert_chan_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (int'(chan_idx) < int'(active_count($past(speed_sel)))));
endmodule

bind lane_lock_sync lls_checker #(.CH_W(CH_W)) u_lls_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .speed_sel    (speed_sel),
  .locked       (locked),
  .chan_idx     (chan_idx),
  .phase_strobe (phase_strobe),
  .lock_event   (lock_event),
  .drop_event   (drop_event)
);

// File: tb/lane_lock_sync_test.sv
module lane_lock_sync_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_pairs = '0;
  logic [1:0]  speed_sel = 2'd0;
  logic [5:0]  lock_thr = 6'd3;
  logic [5:0]  unlock_thr = 6'd1;
  logic        locked;
  logic [3:0]  chan_idx;
  logic        phase_strobe;

  always #5 clk = ~clk;

  lane_lock_sync uut (
    .clk(clk), .rst_n(rst_n), .rx_pairs(rx_pairs), .speed_sel(speed_sel),
    .lock_thr(lock_thr), .unlock_thr(unlock_thr),
    .locked(locked), .chan_idx(chan_idx), .phase_strobe(phase_strobe)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  int strobe_seen = 0;

  // Sequence oldest to newest, as stated in R2.
  bit [1:0] seq_tab [4] = '{2'b11, 2'b01, 2'b10, 2'b00};

  // Behavioural reference.
  int       m_cnt [16];
  bit [1:0] m_hist [16][$];
  bit       m_lock;
  int       m_chan;
  int       m_ph;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_cnt[i] = 0;
      m_hist[i] = '{2'b00, 2'b00, 2'b00};
    end
    m_lock = 0; m_chan = 0; m_ph = 0;
  endtask

  task automatic model_step(logic [31:0] rx, int spd, int lt, int ut);
    int nact;
    bit h [16];
    nact = (spd == 0) ? 4 : ((spd == 1) ? 8 : 16);
    for (int i = 0; i < 16; i++)
      h[i] = (m_hist[i][0] == seq_tab[0]) && (m_hist[i][1] == seq_tab[1]) &&
             (m_hist[i][2] == seq_tab[2]) && (rx[2*i +: 2] == seq_tab[3]);
    if (!m_lock) begin
      int win;
      win = -1;
      for (int i = 0; i < nact; i++) begin
        if (h[i]) begin
          if (m_cnt[i] < 63) m_cnt[i]++;
          if (win < 0 && m_cnt[i] >= lt) win = i;
        end
      end
      if (win >= 0) begin m_lock = 1; m_chan = win; m_ph = 1; end
      else m_ph = (m_ph + 1) % 4;
    end else begin
      if (m_ph == 0) begin
        if (h[m_chan]) begin
          if (m_cnt[m_chan] < lt) m_cnt[m_chan]++;
        end else begin
          int nc;
          nc = (m_cnt[m_chan] == 0) ? 0 : m_cnt[m_chan] - 1;
          if (nc <= ut) begin
            m_lock = 0;
            for (int i = 0; i < 16; i++) m_cnt[i] = 0;
          end else m_cnt[m_chan] = nc;
        end
      end
      m_ph = (m_ph + 1) % 4;
    end
    for (int i = 0; i < 16; i++) begin
      m_hist[i].push_back(rx[2*i +: 2]);
      void'(m_hist[i].pop_front());
    end
  endtask

  task automatic tick(logic [31:0] rx);
    @(negedge clk);
    rx_pairs = rx;
    @(posedge clk);
    model_step(rx, int'(speed_sel), int'(lock_thr), int'(unlock_thr));
    #1;
    chk("R3 locked", int'(locked), int'(m_lock));
    chk("R5 chan_idx", int'(chan_idx), m_chan);
    chk("R6 phase_strobe", int'(phase_strobe), int'(m_lock && m_ph == 0));
    if (phase_strobe) strobe_seen++;
  endtask

  task automatic send_sync(bit [15:0] cand, int reps);
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 16; i++) if (cand[i]) v[2*i +: 2] = seq_tab[k];
        tick(v);
      end
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) tick('0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset locked", int'(locked), 0);
    chk("R1 reset chan", int'(chan_idx), 0);
    chk("R1 reset strobe", int'(phase_strobe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    chk("R1 first cycle locked", int'(locked), 0);

    // R4: candidate 5 inactive at speed 0
    send_sync(16'h0020, 4);
    chk("R4 inactive candidate ignored", int'(locked), 0);

    // seed candidate 2 once, then lock on 5 at speed 1
    speed_sel = 2'd1;
    send_sync(16'h0004, 1);
    send_sync(16'h0020, 3);
    chk("R3 lock after threshold", int'(locked), 1);
    chk("R3 lock chan", int'(chan_idx), 5);

    // R6: four strobes in sixteen cycles
    strobe_seen = 0;
    send_sync(16'h0020, 4);
    chk("R6 strobe count", strobe_seen, 4);

    // R9: other candidate active, selected kept alive
    send_sync(16'h0024, 3);
    chk("R9 chan unchanged", int'(chan_idx), 5);

    // R7: misses bring 3 -> 2 -> 1, drop, while candidate 2 keeps hitting
    send_sync(16'h0004, 2);
    chk("R7 lock lost", int'(locked), 0);

    // R8: candidate 2 must start from zero
    send_sync(16'h0004, 2);
    chk("R8 counts cleared", int'(locked), 0);
    send_sync(16'h0004, 1);
    chk("R8 relock", int'(locked), 1);
    chk("R8 relock chan", int'(chan_idx), 2);

    // R5: tie between 9 and 12
    idle(8);
    chk("R7 lock lost again", int'(locked), 0);
    speed_sel = 2'd2;
    send_sync(16'h1200, 3);
    chk("R5 tie lower index", int'(chan_idx), 9);
    idle(8);

    // R2: wrong order and partial sequences
    for (int r = 0; r < 4; r++)
      for (int k = 3; k >= 0; k--) tick(32'(seq_tab[k]) << 6);
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) tick(32'(seq_tab[k]) << 6);
      tick(32'(2'b01) << 6);
    end
    chk("R2 no hit on bad sequence", int'(locked), 0);
    send_sync(16'h0008, 3);
    chk("R2 proper sequence locks", int'(chan_idx), 3);

    // randomized stretch against the model
    lock_thr = 6'd2;
    unlock_thr = 6'd0;
    lfsr = 32'hACE1_2468;
    for (int c = 0; c < 1200; c++) begin
      if (c % 150 == 0) speed_sel = 2'(c / 150);
      if (c == 600) begin lock_thr = 6'd4; unlock_thr = 6'd2; end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (c % 37 < 8) send_sync(16'(lfsr) & 16'h0F0F, 1);
      else tick(lfsr ^ {lfsr[15:0], lfsr[31:16]});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule